// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the finite-state controller for a single-bus 16-bit load/store datapath. Each clock it drives one control word: which source may place a value on the shared bus, which registers capture it, how the address adder and ALU are steered, and whether memory is enabled for a read or a write. It walks every instruction through a three-step fetch and one decode cycle. It then runs the execute steps of the opcode held in the instruction register, and returns to fetch.

The datapath and the memory stay outside the block. The controller sees the 4-bit opcode from the instruction register, the IR[5] mode bit that picks the immediate operand for ADD and AND, and a memory ready flag. Every memory step stays in place until ready is high. The opcode is a plain control input with no handshake.

The instructions covered are the register ALU operations, address generation, a register jump, PC-relative and base-relative loads and stores, and indirect loads and stores. The indirect forms run as two-pass pointer chases through the address and data registers.

Top module: `mcs_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after release, the outputs form fetch step 1: gate_pc, ld_mar and ld_pc are 1, pc_from_adder is 0, and every other output is 0.
- R2: Fetch runs as three steps followed by one decode cycle. Step 1 is as in R1. Step 2 is a read: mem_en=1, mem_we=0, mdr_from_bus=0. Step 3 sets gate_mdr and ld_ir. In the decode cycle every output is 0.
- R3: In every read step and every write step the outputs stay constant while mem_ready is 0, and the next step begins in the cycle after the one in which mem_ready is 1. In read steps, ld_mdr equals mem_ready.
- R4: Opcodes 0001 (ADD), 0101 (AND) and 1001 (NOT) take one execute cycle with gate_alu, ld_reg and ld_cc set. alu_op is 00, 01 and 10 respectively, sr1_hi is 0, and sr2_imm equals ir_mode for ADD and AND and is 0 for NOT.
- R5: Opcode 1110 (LEA) takes one cycle with gate_addr and ld_reg set, addr1_base=0 and addr2_sel=10 (9-bit offset). ld_cc stays 0.
- R6: Opcode 1100 (JMP) takes one cycle with ld_pc, pc_from_adder and addr1_base set and addr2_sel=00 (zero). ld_reg and ld_cc stay 0.
- R7: Opcodes 0010 (LD) and 0110 (LDR) run three steps. The first is an address step with gate_addr and ld_mar set: addr1_base=0 and addr2_sel=10 for LD, addr1_base=1 and addr2_sel=01 (6-bit offset) for LDR. Then comes a read step, then gate_mdr, ld_reg and ld_cc.
- R8: Opcodes 0011 (ST) and 0111 (STR) run three steps. The first is the same address step as for LD and LDR respectively. The second is a source step with sr1_hi=1, alu_op=11 (pass), gate_alu, mdr_from_bus and ld_mdr set. The third is a write step with mem_en and mem_we set. ld_reg and ld_cc stay 0 throughout.
- R9: Opcode 1010 (LDI) runs five steps: the PC-relative address step, a read, gate_mdr with ld_mar, a second read, then gate_mdr with ld_reg and ld_cc.
- R10: Opcode 1011 (STI) runs five steps: the PC-relative address step, a read, gate_mdr with ld_mar, the source step of R8, then the write step.
- R11: Any other opcode makes the cycle after decode a fetch step 1, with no other outputs asserted in between.
- R12: At most one gate output is 1 in any cycle. mem_we is 1 only with mem_en. Every output that a step does not name is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | 4 | Opcode field of the instruction register |
| ir_mode | input | 1 | IR[5], selects the immediate second operand for ADD/AND |
| mem_ready | input | 1 | Memory has completed the current read or write |
| gate_pc | output | 1 | Drive PC onto the bus |
| gate_mdr | output | 1 | Drive MDR onto the bus |
| gate_alu | output | 1 | Drive the ALU result onto the bus |
| gate_addr | output | 1 | Drive the address adder result onto the bus |
| ld_mar | output | 1 | Load MAR from the bus |
| ld_mdr | output | 1 | Load MDR |
| ld_ir | output | 1 | Load IR from the bus |
| ld_pc | output | 1 | Load PC |
| ld_reg | output | 1 | Write the register file at IR[11:9] |
| ld_cc | output | 1 | Update the condition codes |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory access is a write |
| mdr_from_bus | output | 1 | MDR source: 1 bus, 0 memory |
| sr1_hi | output | 1 | First register read port index: 1 IR[11:9], 0 IR[8:6] |
| sr2_imm | output | 1 | ALU second operand: 1 sign-extended immediate, 0 register |
| alu_op | output | 2 | 00 add, 01 and, 10 not, 11 pass first operand |
| addr1_base | output | 1 | Address adder first operand: 1 base register, 0 PC |
| addr2_sel | output | 2 | Address adder second operand: 00 zero, 01 6-bit offset, 10 9-bit offset |
| pc_from_adder | output | 1 | PC source: 1 address adder, 0 incremented PC |

## Verification
The assertions assume that ir_opcode and ir_mode hold still from the cycle after IR is loaded until the next fetch. They also assume that mem_ready is acted on only while a read or write step is pending. The stimulus changes the opcode and mode only in the cycle that asserts ld_ir. It holds mem_ready low for 0 to 3 cycles in each memory step, in a rotating pattern. Outside memory steps it toggles mem_ready, so any effect of the flag there would show up in the output comparison. The instruction mix includes every supported opcode, both operand modes, and several unused codes.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int OPC_W = 4;
  localparam int ALU_W = 2;
  localparam int A2_W  = 2;

  localparam logic [OPC_W-1:0] OP_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OP_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OP_NOT = 4'b1001;
  localparam logic [OPC_W-1:0] OP_LEA = 4'b1110;
  localparam logic [OPC_W-1:0] OP_JMP = 4'b1100;
  localparam logic [OPC_W-1:0] OP_LD  = 4'b0010;
  localparam logic [OPC_W-1:0] OP_ST  = 4'b0011;
  localparam logic [OPC_W-1:0] OP_LDR = 4'b0110;
  localparam logic [OPC_W-1:0] OP_STR = 4'b0111;
  localparam logic [OPC_W-1:0] OP_LDI = 4'b1010;
  localparam logic [OPC_W-1:0] OP_STI = 4'b1011;

  localparam logic [ALU_W-1:0] ALU_ADD  = 2'b00;
  localparam logic [ALU_W-1:0] ALU_AND  = 2'b01;
  localparam logic [ALU_W-1:0] ALU_NOT  = 2'b10;
  localparam logic [ALU_W-1:0] ALU_PASS = 2'b11;

  localparam logic [A2_W-1:0] A2_ZERO = 2'b00;
  localparam logic [A2_W-1:0] A2_OFF6 = 2'b01;
  localparam logic [A2_W-1:0] A2_OFF9 = 2'b10;

  typedef enum logic [3:0] {
    S_FETCH_ADDR, S_FETCH_READ, S_FETCH_IR, S_DECODE,
    S_EXEC_ALU, S_EXEC_LEA, S_EXEC_JMP,
    S_ADDR_PC9, S_ADDR_BASE6, S_READ_A, S_PTR_MOVE, S_READ_B,
    S_WRITEBACK, S_SRC_MDR, S_WRITE
  } state_t;

  typedef struct packed {
    logic              gate_pc;
    logic              gate_mdr;
    logic              gate_alu;
    logic              gate_addr;
    logic              ld_mar;
    logic              ld_mdr;
    logic              ld_ir;
    logic              ld_pc;
    logic              ld_reg;
    logic              ld_cc;
    logic              mem_en;
    logic              mem_we;
    logic              mdr_from_bus;
    logic              sr1_hi;
    logic              sr2_imm;
    logic [ALU_W-1:0]  alu_op;
    logic              addr1_base;
    logic [A2_W-1:0]   addr2_sel;
    logic              pc_from_adder;
  } ctrl_t;

endpackage

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
(
  input  state_t           cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             mem_ready,
  output state_t           nxt
);

  always_comb begin
    nxt = S_FETCH_ADDR;
    case (cur)
      S_FETCH_ADDR: nxt = S_FETCH_READ;
      S_FETCH_READ: nxt = mem_ready ? S_FETCH_IR : S_FETCH_READ;
      S_FETCH_IR:   nxt = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OP_ADD, OP_AND, OP_NOT:       nxt = S_EXEC_ALU;
          OP_LEA:                       nxt = S_EXEC_LEA;
          OP_JMP:                       nxt = S_EXEC_JMP;
          OP_LD, OP_ST, OP_LDI, OP_STI: nxt = S_ADDR_PC9;
          OP_LDR, OP_STR:               nxt = S_ADDR_BASE6;
          default:                      nxt = S_FETCH_ADDR;
        endcase
      end
      S_ADDR_PC9: begin
        case (opcode)
          OP_LD, OP_LDI, OP_STI: nxt = S_READ_A;
          OP_ST:                 nxt = S_SRC_MDR;
          default:               nxt = S_FETCH_ADDR;
        endcase
      end
      S_ADDR_BASE6: begin
        case (opcode)
          OP_LDR:  nxt = S_READ_A;
          OP_STR:  nxt = S_SRC_MDR;
          default: nxt = S_FETCH_ADDR;
        endcase
      end
      S_READ_A: begin
        if (!mem_ready) nxt = S_READ_A;
        else begin
          case (opcode)
            OP_LD, OP_LDR:  nxt = S_WRITEBACK;
            OP_LDI, OP_STI: nxt = S_PTR_MOVE;
            default:        nxt = S_FETCH_ADDR;
          endcase
        end
      end
      S_PTR_MOVE: begin
        case (opcode)
          OP_LDI:  nxt = S_READ_B;
          OP_STI:  nxt = S_SRC_MDR;
          default: nxt = S_FETCH_ADDR;
        endcase
      end
      S_READ_B:  nxt = mem_ready ? S_WRITEBACK : S_READ_B;
      S_SRC_MDR: nxt = S_WRITE;
      S_WRITE:   nxt = mem_ready ? S_FETCH_ADDR : S_WRITE;
      default:   nxt = S_FETCH_ADDR;
    endcase
  end

endmodule

// File: rtl/mcs_state_reg.sv
module mcs_state_reg
  import mcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mem_ready,
  input  state_t nxt,
  output state_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= S_FETCH_ADDR;
    else        cur <= nxt;
  end

  logic waiting;
  assign waiting = (cur == S_FETCH_READ || cur == S_READ_A ||
                    cur == S_READ_B || cur == S_WRITE) && !mem_ready;

  // R3: a memory step is not left before the ready flag
  p_mem_wait_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> $stable(cur));

endmodule

// File: rtl/mcs_ctrl_decode.sv
module mcs_ctrl_decode
  import mcs_pkg::*;
(
  input  state_t           cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             mode,
  input  logic             mem_ready,
  output ctrl_t            cw
);

  always_comb begin
    cw = '0;
    case (cur)
      S_FETCH_ADDR: begin
        cw.gate_pc = 1'b1;
        cw.ld_mar  = 1'b1;
        cw.ld_pc   = 1'b1;
      end
      S_FETCH_READ, S_READ_A, S_READ_B: begin
        cw.mem_en = 1'b1;
        cw.ld_mdr = mem_ready;
      end
      S_FETCH_IR: begin
        cw.gate_mdr = 1'b1;
        cw.ld_ir    = 1'b1;
      end
      S_EXEC_ALU: begin
        cw.gate_alu = 1'b1;
        cw.ld_reg   = 1'b1;
        cw.ld_cc    = 1'b1;
        case (opcode)
          OP_ADD:  cw.alu_op = ALU_ADD;
          OP_AND:  cw.alu_op = ALU_AND;
          default: cw.alu_op = ALU_NOT;
        endcase
        cw.sr2_imm = mode && (opcode != OP_NOT);
      end
      S_EXEC_LEA: begin
        cw.addr2_sel = A2_OFF9;
        cw.gate_addr = 1'b1;
        cw.ld_reg    = 1'b1;
      end
      S_EXEC_JMP: begin
        cw.addr1_base    = 1'b1;
        cw.addr2_sel     = A2_ZERO;
        cw.pc_from_adder = 1'b1;
        cw.ld_pc         = 1'b1;
      end
      S_ADDR_PC9: begin
        cw.addr2_sel = A2_OFF9;
        cw.gate_addr = 1'b1;
        cw.ld_mar    = 1'b1;
      end
      S_ADDR_BASE6: begin
        cw.addr1_base = 1'b1;
        cw.addr2_sel  = A2_OFF6;
        cw.gate_addr  = 1'b1;
        cw.ld_mar     = 1'b1;
      end
      S_PTR_MOVE: begin
        cw.gate_mdr = 1'b1;
        cw.ld_mar   = 1'b1;
      end
      S_WRITEBACK: begin
        cw.gate_mdr = 1'b1;
        cw.ld_reg   = 1'b1;
        cw.ld_cc    = 1'b1;
      end
      S_SRC_MDR: begin
        cw.sr1_hi       = 1'b1;
        cw.alu_op       = ALU_PASS;
        cw.gate_alu     = 1'b1;
        cw.mdr_from_bus = 1'b1;
        cw.ld_mdr       = 1'b1;
      end
      S_WRITE: begin
        cw.mem_en = 1'b1;
        cw.mem_we = 1'b1;
      end
      default: cw = '0;
    endcase
  end

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] ir_opcode,
  input  logic             ir_mode,
  input  logic             mem_ready,
  output logic             gate_pc,
  output logic             gate_mdr,
  output logic             gate_alu,
  output logic             gate_addr,
  output logic             ld_mar,
  output logic             ld_mdr,
  output logic             ld_ir,
  output logic             ld_pc,
  output logic             ld_reg,
  output logic             ld_cc,
  output logic             mem_en,
  output logic             mem_we,
  output logic             mdr_from_bus,
  output logic             sr1_hi,
  output logic             sr2_imm,
  output logic [ALU_W-1:0] alu_op,
  output logic             addr1_base,
  output logic [A2_W-1:0]  addr2_sel,
  output logic             pc_from_adder
);

  state_t cur_q;
  state_t nxt_d;
  ctrl_t  cw;

  mcs_next_state u_next (
    .cur       (cur_q),
    .opcode    (ir_opcode),
    .mem_ready (mem_ready),
    .nxt       (nxt_d)
  );

  mcs_state_reg u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ready (mem_ready),
    .nxt       (nxt_d),
    .cur       (cur_q)
  );

  mcs_ctrl_decode u_decode (
    .cur       (cur_q),
    .opcode    (ir_opcode),
    .mode      (ir_mode),
    .mem_ready (mem_ready),
    .cw        (cw)
  );

  assign gate_pc       = cw.gate_pc;
  assign gate_mdr      = cw.gate_mdr;
  assign gate_alu      = cw.gate_alu;
  assign gate_addr     = cw.gate_addr;
  assign ld_mar        = cw.ld_mar;
  assign ld_mdr        = cw.ld_mdr;
  assign ld_ir         = cw.ld_ir;
  assign ld_pc         = cw.ld_pc;
  assign ld_reg        = cw.ld_reg;
  assign ld_cc         = cw.ld_cc;
  assign mem_en        = cw.mem_en;
  assign mem_we        = cw.mem_we;
  assign mdr_from_bus  = cw.mdr_from_bus;
  assign sr1_hi        = cw.sr1_hi;
  assign sr2_imm       = cw.sr2_imm;
  assign alu_op        = cw.alu_op;
  assign addr1_base    = cw.addr1_base;
  assign addr2_sel     = cw.addr2_sel;
  assign pc_from_adder = cw.pc_from_adder;

  // R12: a single bus driver per cycle
  p_single_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gate_pc, gate_mdr, gate_alu, gate_addr}) <= 1);

  // R12: writes only as part of an enabled access
  p_we_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R2: the cycle after the IR load is an idle decode cycle
  p_decode_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> !(gate_pc || gate_mdr || gate_alu || gate_addr || ld_mar ||
                ld_mdr || ld_pc || ld_reg || ld_cc || mem_en));

  // R3: a pending access keeps its direction until ready
  p_access_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_ready) |=> (mem_en && mem_we == $past(mem_we)));

  // R3: MDR takes memory data only on a completed read
  p_mdr_from_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mdr && !mdr_from_bus) |-> (mem_en && mem_ready && !mem_we));

  // R5: address results written to a register leave the CC alone
  p_lea_no_cc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_addr && ld_reg) |-> !ld_cc);

  // R6: a jump writes neither the register file nor the CC
  p_jump_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc && pc_from_adder) |-> (!ld_reg && !ld_cc));

endmodule

// File: tb/mcs_sequencer_tb_top.sv
module mcs_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ir_opcode;
  logic       ir_mode;
  logic       mem_ready;
  logic gate_pc, gate_mdr, gate_alu, gate_addr, ld_mar, ld_mdr, ld_ir, ld_pc;
  logic ld_reg, ld_cc, mem_en, mem_we, mdr_from_bus, sr1_hi, sr2_imm;
  logic [1:0] alu_op;
  logic addr1_base;
  logic [1:0] addr2_sel;
  logic pc_from_adder;

  always #2 clk = ~clk;

  mcs_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_mode(ir_mode),
    .mem_ready(mem_ready), .gate_pc(gate_pc), .gate_mdr(gate_mdr),
    .gate_alu(gate_alu), .gate_addr(gate_addr), .ld_mar(ld_mar),
    .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_pc(ld_pc), .ld_reg(ld_reg),
    .ld_cc(ld_cc), .mem_en(mem_en), .mem_we(mem_we),
    .mdr_from_bus(mdr_from_bus), .sr1_hi(sr1_hi), .sr2_imm(sr2_imm),
    .alu_op(alu_op), .addr1_base(addr1_base), .addr2_sel(addr2_sel),
    .pc_from_adder(pc_from_adder)
  );

  // bench-side bit layout of the observed control word
  localparam int B_GPC = 20, B_GMDR = 19, B_GALU = 18, B_GADR = 17;
  localparam int B_LMAR = 16, B_LMDR = 15, B_LIR = 14, B_LPC = 13;
  localparam int B_LREG = 12, B_LCC = 11, B_MEN = 10, B_MWE = 9;
  localparam int B_MBUS = 8, B_SRHI = 7, B_IMM = 6, B_ALU = 4;
  localparam int B_A1 = 3, B_A2 = 1, B_PCA = 0;

  typedef struct {
    logic [20:0] w;
    bit          mem;
    bit          rd;
    string       tag;
  } step_t;

  step_t q[$];
  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  int prog_op[17]   = '{1, 1, 5, 5, 9, 14, 12, 2, 6, 3, 7, 10, 11, 0, 15, 13, 4};
  bit prog_mode[17] = '{0, 1, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam int PASSES = 3;

  function automatic logic [20:0] bits(input int b);
    logic [20:0] v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  function automatic logic [20:0] fld(input int lsb, input int val);
    logic [20:0] v = '0;
    v = 21'(val) << lsb;
    return v;
  endfunction

  task automatic push(input logic [20:0] w, input bit mem, input bit rd,
                      input string tag);
    step_t s;
    s.w = w; s.mem = mem; s.rd = rd; s.tag = tag;
    q.push_back(s);
  endtask

  task automatic push_fetch(input string t1);
    push(bits(B_GPC) | bits(B_LMAR) | bits(B_LPC), 0, 0, t1);
    push(bits(B_MEN), 1, 1, "R2 R3 fetch read");
    push(bits(B_GMDR) | bits(B_LIR), 0, 0, "R2 IR load");
    push('0, 0, 0, "R2 R12 decode");
  endtask

  task automatic push_read(input string t);
    push(bits(B_MEN), 1, 1, t);
  endtask

  task automatic push_src(input string t);
    push(bits(B_SRHI) | fld(B_ALU, 3) | bits(B_GALU) | bits(B_MBUS) |
         bits(B_LMDR), 0, 0, t);
  endtask

  task automatic push_write(input string t);
    push(bits(B_MEN) | bits(B_MWE), 1, 0, t);
  endtask

  logic [20:0] a9, a6, wb;
  bit unknown_op;

  task automatic expand(input logic [3:0] op, input bit md);
    a9 = bits(B_GADR) | bits(B_LMAR) | fld(B_A2, 2);
    a6 = bits(B_GADR) | bits(B_LMAR) | bits(B_A1) | fld(B_A2, 1);
    wb = bits(B_GMDR) | bits(B_LREG) | bits(B_LCC);
    unknown_op = 1'b0;
    case (op)
      4'b0001: push(bits(B_GALU) | bits(B_LREG) | bits(B_LCC) | fld(B_ALU, 0) |
                    (md ? bits(B_IMM) : '0), 0, 0, "R4 ADD");
      4'b0101: push(bits(B_GALU) | bits(B_LREG) | bits(B_LCC) | fld(B_ALU, 1) |
                    (md ? bits(B_IMM) : '0), 0, 0, "R4 AND");
      4'b1001: push(bits(B_GALU) | bits(B_LREG) | bits(B_LCC) | fld(B_ALU, 2),
                    0, 0, "R4 NOT");
      4'b1110: push(bits(B_GADR) | bits(B_LREG) | fld(B_A2, 2), 0, 0, "R5 LEA");
      4'b1100: push(bits(B_A1) | bits(B_LPC) | bits(B_PCA), 0, 0, "R6 JMP");
      4'b0010: begin
        push(a9, 0, 0, "R7 LD addr"); push_read("R7 R3 LD read");
        push(wb, 0, 0, "R7 LD writeback");
      end
      4'b0110: begin
        push(a6, 0, 0, "R7 LDR addr"); push_read("R7 R3 LDR read");
        push(wb, 0, 0, "R7 LDR writeback");
      end
      4'b0011: begin
        push(a9, 0, 0, "R8 ST addr"); push_src("R8 ST source");
        push_write("R8 R3 ST write");
      end
      4'b0111: begin
        push(a6, 0, 0, "R8 STR addr"); push_src("R8 STR source");
        push_write("R8 R3 STR write");
      end
      4'b1010: begin
        push(a9, 0, 0, "R9 LDI addr"); push_read("R9 R3 LDI read1");
        push(bits(B_GMDR) | bits(B_LMAR), 0, 0, "R9 LDI pointer");
        push_read("R9 R3 LDI read2"); push(wb, 0, 0, "R9 LDI writeback");
      end
      4'b1011: begin
        push(a9, 0, 0, "R10 STI addr"); push_read("R10 R3 STI read");
        push(bits(B_GMDR) | bits(B_LMAR), 0, 0, "R10 STI pointer");
        push_src("R10 STI source"); push_write("R10 R3 STI write");
      end
      default: unknown_op = 1'b1;
    endcase
  endtask

  function automatic logic [20:0] observed();
    return {gate_pc, gate_mdr, gate_alu, gate_addr, ld_mar, ld_mdr, ld_ir,
            ld_pc, ld_reg, ld_cc, mem_en, mem_we, mdr_from_bus, sr1_hi,
            sr2_imm, alu_op, addr1_base, addr2_sel, pc_from_adder};
  endfunction

  task automatic check(input logic [20:0] exp, input string tag);
    logic [20:0] act;
    act = observed();
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    int pidx = 0;
    int total;
    int mem_cnt = 0;
    int wait_left = 0;
    bit in_wait = 1'b0;
    int cyc = 0;
    step_t s;
    logic [20:0] exp;
    total = 17 * PASSES;
    rst_n = 1'b0; ir_opcode = 4'b0000; ir_mode = 1'b0; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(bits(B_GPC) | bits(B_LMAR) | bits(B_LPC), "R1 in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    push_fetch("R1 first fetch");
    while (!done) begin
      s = q[0];
      if (s.mem) begin
        if (!in_wait) begin wait_left = mem_cnt % 4; in_wait = 1'b1; end
        mem_ready = (wait_left == 0);
      end else begin
        mem_ready = (cyc % 3 == 0);
      end
      #1;
      exp = s.w;
      if (s.rd) exp[B_LMDR] = mem_ready;
      check(exp, s.tag);
      if (s.mem && !mem_ready) begin
        wait_left--;
      end else begin
        void'(q.pop_front());
        if (s.mem) begin in_wait = 1'b0; mem_cnt++; end
        if (s.w[B_LIR]) begin
          ir_opcode = 4'(prog_op[pidx % 17]);
          ir_mode   = prog_mode[pidx % 17];
          pidx++;
        end
        if (s.tag == "R2 R12 decode") begin
          expand(ir_opcode, ir_mode);
          if (q.size() == 0 && pidx < total) begin
            push_fetch(unknown_op ? "R11 unused opcode then fetch"
                                  : "R2 fetch addr");
          end
        end
        if (q.size() == 0) begin
          if (pidx < total) push_fetch("R2 fetch addr");
          else done = 1'b1;
        end
      end
      cyc++;
      @(posedge clk); #1;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule